// File: doc/BRIEF.md
# Partial Window Address Command Generator

This block turns a rectangular update region, given as origin (x, y) and size (w, h) on a panel of PANEL_W × PANEL_H pixels (800 × 480 by default), into the ordered run of command and data bytes that prepares a display controller for a partial RAM write. The run sets the RAM entry mode, the X and Y address windows, and the X and Y start counters. It does not send any pixel data.

The panel stores its rows from the bottom upward. The block therefore mirrors the Y axis: the lowest stored row of the region is y_rev = PANEL_H − y − h, and the top row is y_rev + h − 1 = PANEL_H − 1 − y. The Y window is sent with that top row first, so that it works with a decrementing Y entry mode. X is sent in pixel units. Each byte leaves with a flag that tells a downstream serial framer whether the byte is a command or data. The byte stream uses a valid/ready handshake.

A request is accepted only while no stream is in progress. An illegal region raises a one-cycle error pulse and produces no bytes. A one-cycle done pulse follows the acceptance of the final byte.

Top module: `win_addr_gen`

## Requirements
- R1: While reset is held, and in the cycle after it, out_valid, done and err are low.
- R2: An accepted legal request starts a stream in the next cycle. The stream begins with command byte 0x11 followed by data byte 0x01.
- R3: Third comes command 0x44 with four data bytes, in this order: x[7:0], x[15:8], (x+w−1)[7:0], (x+w−1)[15:8].
- R4: Next comes command 0x45 with four data bytes, in this order: (479−y)[7:0], (479−y)[15:8], (480−y−h)[7:0], (480−y−h)[15:8]. These values are for PANEL_H = 480.
- R5: Next comes command 0x4E with data x[7:0], then x[15:8].
- R6: Last comes command 0x4F with data (479−y)[7:0], then (479−y)[15:8]. A stream is exactly 18 bytes long.
- R7: out_cmd is 1 on the five command bytes (0x11, 0x44, 0x45, 0x4E, 0x4F) and 0 on every data byte.
- R8: Some requests are rejected. A request is rejected when x or w is not a multiple of 8, when w or h is zero, when x+w > 800, or when y+h > 480. A rejected request raises err for one cycle, in the cycle after it is accepted, and no byte is emitted.
- R9: While out_valid is high and out_ready is low, out_byte and out_cmd hold their values. The stream advances only on a cycle in which both out_valid and out_ready are high.
- R10: done is high for exactly one cycle, the cycle after the last 0x4F data byte is accepted. out_valid is low in that same cycle.
- R11: A request raised while a stream is in progress is ignored. The current stream continues unchanged, and no second stream follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Region request, accepted when no stream is running |
| req_x | input | 16 | Region left column, pixels |
| req_y | input | 16 | Region top row, pixels |
| req_w | input | 16 | Region width, pixels |
| req_h | input | 16 | Region height, rows |
| out_valid | output | 1 | A byte is offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Command or data byte |
| out_cmd | output | 1 | 1 = command byte, 0 = data byte |
| done | output | 1 | One-cycle pulse after the final byte is accepted |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions assume that out_ready can change freely from cycle to cycle. They assume that a request's fields carry meaning only in the cycle in which req_valid is high while the block is idle. The bench drives out_ready from $urandom at every cycle to exercise the hold rule. It mixes aligned, in-range random regions with deliberately misaligned, oversized and zero-size regions, plus the extreme corners of the panel. It also raises a competing request in the middle of a stream, and lowers req_valid before the stream ends.

// File: rtl/win_pkg.sv
// Shared types and constants for the partial window address generator.
// Assumes 16-bit coordinates, because each address goes out as a low byte
// then a high byte.
package win_pkg;
    localparam int COORD_W  = 16;
    localparam int N_BYTES  = 18;
    localparam int IDX_W    = $clog2(N_BYTES);

    localparam logic [7:0] CMD_ENTRY = 8'h11;
    localparam logic [7:0] MODE_XINC_YDEC = 8'h01;
    localparam logic [7:0] CMD_XWIN  = 8'h44;
    localparam logic [7:0] CMD_YWIN  = 8'h45;
    localparam logic [7:0] CMD_XCNT  = 8'h4E;
    localparam logic [7:0] CMD_YCNT  = 8'h4F;

    // Resolved window in controller address terms
    typedef struct packed {
        logic [COORD_W-1:0] x_first;
        logic [COORD_W-1:0] x_last;
        logic [COORD_W-1:0] y_top;
        logic [COORD_W-1:0] y_bot;
    } win_t;
endpackage

// File: rtl/win_check.sv
// Validates a region and converts it into mirrored controller addresses.
// Purely combinational. Its outputs are meaningful only when ok is high.
module win_check
    import win_pkg::*;
#(
    parameter int PANEL_W = 800,
    parameter int PANEL_H = 480,
    parameter int ALIGN   = 8
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] w,
    input  logic [COORD_W-1:0] h,
    output logic               ok,
    output win_t               win
);
    localparam int AL_BITS = $clog2(ALIGN);
    localparam logic [COORD_W:0] LIM_W = (COORD_W+1)'(PANEL_W);
    localparam logic [COORD_W:0] LIM_H = (COORD_W+1)'(PANEL_H);

    logic             aligned;
    logic [COORD_W:0] x_span, y_span;

    // Alignment test; a unit alignment needs no test at all
    generate
        if (AL_BITS == 0) begin : g_noalign
            assign aligned = 1'b1;
        end else begin : g_align
            assign aligned = (x[AL_BITS-1:0] == '0) && (w[AL_BITS-1:0] == '0);
        end
    endgenerate

    // Range test on widened sums, so that no carry is lost
    always_comb begin
        x_span = {1'b0, x} + {1'b0, w};
        y_span = {1'b0, y} + {1'b0, h};
        ok = aligned && (w != '0) && (h != '0) && (x_span <= LIM_W) && (y_span <= LIM_H);
    end

    // Address derivation with the row axis mirrored
    always_comb begin
        win.x_first = x;
        win.x_last  = x + w - 1'b1;
        win.y_bot   = COORD_W'(PANEL_H) - y - h;
        win.y_top   = COORD_W'(PANEL_H - 1) - y;
    end
endmodule

// File: rtl/win_seq.sv
// Stream sequencer: accepts a request when idle, holds the resolved window,
// and steps a byte index on each downstream handshake. Raises done after the
// final byte and err for a rejected request.
module win_seq
    import win_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ok,
    input  win_t             win_in,
    input  logic             out_ready,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output win_t             win_q,
    output logic             done,
    output logic             err
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

    logic accept, step, last_step;

    // Handshake decode
    always_comb begin
        accept    = start && !active;
        step      = active && out_ready;
        last_step = step && (idx == LAST);
    end

    // State, index and window register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            win_q  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= last_step;
            err  <= accept && !ok;
            if (accept && ok) begin
                active <= 1'b1;
                idx    <= '0;
                win_q  <= win_in;
            end else if (last_step) begin
                active <= 1'b0;
                idx    <= '0;
            end else if (step) begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        active && !out_ready |=> active && $stable(idx)) else $error("idx moved without handshake"); // R9
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && done |-> $past(active && out_ready && idx == LAST)) else $error("done without final byte"); // R10
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !active) else $error("err during stream"); // R8
    AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        active && $past(active) |-> $stable(win_q)) else $error("window changed mid stream"); // R11
endmodule

// File: rtl/win_mux.sv
// Byte selector: maps the stream index onto a command or an address byte.
// Combinational; the order of the bytes is the controller's command protocol.
module win_mux
    import win_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  win_t             win,
    output logic [7:0]       byte_o,
    output logic             is_cmd
);
    // Index to byte lookup
    always_comb begin
        is_cmd = 1'b0;
        byte_o = 8'h00;
        case (idx)
            5'd0:  begin is_cmd = 1'b1; byte_o = CMD_ENTRY; end
            5'd1:  byte_o = MODE_XINC_YDEC;
            5'd2:  begin is_cmd = 1'b1; byte_o = CMD_XWIN; end
            5'd3:  byte_o = win.x_first[7:0];
            5'd4:  byte_o = win.x_first[15:8];
            5'd5:  byte_o = win.x_last[7:0];
            5'd6:  byte_o = win.x_last[15:8];
            5'd7:  begin is_cmd = 1'b1; byte_o = CMD_YWIN; end
            5'd8:  byte_o = win.y_top[7:0];
            5'd9:  byte_o = win.y_top[15:8];
            5'd10: byte_o = win.y_bot[7:0];
            5'd11: byte_o = win.y_bot[15:8];
            5'd12: begin is_cmd = 1'b1; byte_o = CMD_XCNT; end
            5'd13: byte_o = win.x_first[7:0];
            5'd14: byte_o = win.x_first[15:8];
            5'd15: begin is_cmd = 1'b1; byte_o = CMD_YCNT; end
            5'd16: byte_o = win.y_top[7:0];
            5'd17: byte_o = win.y_top[15:8];
            default: ;
        endcase
    end
endmodule

// File: rtl/win_addr_gen.sv
// Partial window address command generator, top level.
// Checks a region, mirrors its rows, and streams the tagged setup bytes
// under a valid/ready handshake. Assumes the downstream framer
// serialises the bytes in the order it accepts them.
module win_addr_gen
    import win_pkg::*;
#(
    parameter int PANEL_W = 800,
    parameter int PANEL_H = 480,
    parameter int ALIGN   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic [COORD_W-1:0] req_w,
    input  logic [COORD_W-1:0] req_h,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_byte,
    output logic               out_cmd,
    output logic               done,
    output logic               err
);
    logic             ok;
    win_t             win_c, win_q;
    logic [IDX_W-1:0] idx;
    logic             active;

    win_check #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .ALIGN(ALIGN)) u_check (
        .x(req_x), .y(req_y), .w(req_w), .h(req_h), .ok(ok), .win(win_c)
    );

    win_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(req_valid), .ok(ok), .win_in(win_c),
        .out_ready(out_ready), .active(active), .idx(idx), .win_q(win_q),
        .done(done), .err(err)
    );

    win_mux u_mux (.idx(idx), .win(win_q), .byte_o(out_byte), .is_cmd(out_cmd));

    assign out_valid = active;

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_cmd)) else $error("byte not held"); // R9
    AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_cmd && out_byte == CMD_ENTRY) else $error("stream did not open with entry command"); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && !err) else $error("done overlaps stream or err"); // R10
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid) else $error("bytes after rejection"); // R8
endmodule

// File: tb/win_addr_gen_bench.sv
`timescale 1ns/1ps
module win_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_x = '0, req_y = '0, req_w = '0, req_h = '0;
    logic        out_ready = 1'b0;
    logic        out_valid, out_cmd, done, err;
    logic [7:0]  out_byte;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    win_addr_gen u_win_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
        .req_w(req_w), .req_h(req_h), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .out_cmd(out_cmd), .done(done), .err(err)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit legal(input int x, input int y, input int w, input int h);
        return (x % 8 == 0) && (w % 8 == 0) && (w > 0) && (h > 0) && (x + w <= 800) && (y + h <= 480);
    endfunction

    // Expected {cmd flag, byte} for stream position i
    function automatic logic [8:0] exp_byte(input int i, input int x, input int y, input int w, input int h);
        int xe = x + w - 1;
        int yt = 479 - y;
        int yb = 480 - y - h;
        case (i)
            0: return {1'b1, 8'h11};   1: return {1'b0, 8'h01};
            2: return {1'b1, 8'h44};
            3: return {1'b0, 8'(x)};   4: return {1'b0, 8'(x >> 8)};
            5: return {1'b0, 8'(xe)};  6: return {1'b0, 8'(xe >> 8)};
            7: return {1'b1, 8'h45};
            8: return {1'b0, 8'(yt)};  9: return {1'b0, 8'(yt >> 8)};
            10: return {1'b0, 8'(yb)}; 11: return {1'b0, 8'(yb >> 8)};
            12: return {1'b1, 8'h4E};
            13: return {1'b0, 8'(x)};  14: return {1'b0, 8'(x >> 8)};
            15: return {1'b1, 8'h4F};
            16: return {1'b0, 8'(yt)}; 17: return {1'b0, 8'(yt >> 8)};
            default: return 9'h0;
        endcase
    endfunction

    function automatic string req_of(input int i);
        if (i < 2) return "R2";
        if (i < 7) return "R3";
        if (i < 12) return "R4";
        if (i < 15) return "R5";
        return "R6";
    endfunction

    task automatic run(input int x, input int y, input int w, input int h, input bit intrude);
        int got = 0;
        bit saw_done = 1'b0;
        logic [7:0] held_b = '0;
        logic       held_c = 1'b0;
        bit         holding = 1'b0;
        @(negedge clk);
        req_x = 16'(x); req_y = 16'(y); req_w = 16'(w); req_h = 16'(h);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal(x, y, w, h)) begin
            check(err == 1'b1 && out_valid == 1'b0, "R8 reject pulse", {err, out_valid}, 2'b10);
            @(negedge clk);
            check(err == 1'b0 && out_valid == 1'b0, "R8 no bytes after reject", {err, out_valid}, 2'b00);
            return;
        end
        check(err == 1'b0, "R8 legal not rejected", err, 0);
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (done) begin saw_done = 1'b1; break; end
            if (intrude && cyc == 3) begin
                req_x = 16'd0; req_y = 16'd0; req_w = 16'd8; req_h = 16'd8; req_valid = 1'b1;
            end
            if (intrude && cyc == 4) req_valid = 1'b0;
            if (holding)
                check(out_valid && out_byte == held_b && out_cmd == held_c, "R9 byte held",
                      {out_cmd, out_byte}, {held_c, held_b});
            out_ready = ($urandom % 3) != 0;
            if (out_valid) begin
                holding = !out_ready;
                held_b = out_byte; held_c = out_cmd;
                if (out_ready) begin
                    logic [8:0] e = exp_byte(got, x, y, w, h);
                    if (e[8] != out_cmd) check(1'b0, "R7 tag", out_cmd, e[8]);
                    check({out_cmd, out_byte} == e, req_of(got), {out_cmd, out_byte}, e);
                    got++;
                end
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(saw_done && got == 18, "R10 done after 18 bytes", got, 18);
        check(out_valid == 1'b0, "R10 idle with done", out_valid, 0);
        @(negedge clk);
        check(done == 1'b0 && out_valid == 1'b0, intrude ? "R11 no second stream" : "R10 done one cycle",
              {done, out_valid}, 0);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1 in reset", {out_valid, done, err}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1 after reset", {out_valid, done, err}, 0);
        // Directed corners
        run(0, 0, 800, 480, 1'b0);
        run(792, 479, 8, 1, 1'b0);
        run(256, 200, 264, 56, 1'b1);
        run(4, 0, 8, 8, 1'b0);
        run(0, 0, 12, 8, 1'b0);
        run(0, 0, 0, 8, 1'b0);
        run(0, 0, 8, 0, 1'b0);
        run(800, 0, 8, 8, 1'b0);
        run(0, 470, 8, 11, 1'b0);
        run(8, 0, 800, 8, 1'b0);
        // Random mix
        for (int k = 0; k < 60; k++) begin
            int x, y, w, h;
            x = int'(($urandom % 100) * 8);
            w = int'((($urandom % 100) + 1) * 8);
            y = int'($urandom % 480);
            h = int'(($urandom % 480) + 1);
            if ($urandom % 4 == 0) x = x + 1 + int'($urandom % 7);
            run(x, y, w, h, ($urandom % 5) == 0);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule